// File: doc/BRIEF.md
# Successive-Approximation Converter Sequencer with Framed Serial Output

This block is the digital controller of a 14-bit successive-approximation converter. A falling edge on the active-low start strobe begins a conversion. The block then counts a fixed number of master-clock cycles and sends the result as a 16-slot serial word. The serial clock is made from the master clock and runs only while a word is being sent.

A behavioural stand-in supplies the parallel result and an over-range flag. The block captures both in the cycle where it detects the start edge.

The word can go out in one of two ways. In the first mode it is sent as soon as the conversion finishes. In the second mode the block holds the data line released until the receiver pulls the frame-sync input low. A standby or nap request blocks new conversions. Reset aborts any work in progress.

Top module: `adc_conv_sequencer`

## Requirements
- R1: A falling edge of `start_n` seen at master-clock edge E0 while idle starts a conversion. `busy` is high from E0 onward. `sample_data` and `sample_ovr` are captured at E0, and later changes to them do not affect the word.
- R2: A conversion lasts 24 master-clock cycles (edges E1 to E24). `sclk` stays low through E24.
- R3: The word is 16 bits, sent in this order: `sample_ovr`, then `sample_data[13]` down to `sample_data[0]`, then a 0.
- R4: `sdo` takes a new bit only on the master edge where `sclk` rises, and holds that bit across the following falling edge of `sclk`.
- R5: `sclk` runs at half the master-clock rate, with exactly 16 high pulses per word. It is low at all other times.
- R6: With `mode_sel` low at the end of the conversion, `sdo_oe` rises at E24 and the first `sclk` rise is at E25. `busy` and `sdo_oe` fall at E56, together with the last fall of `sclk`.
- R7: With `mode_sel` high at the end of the conversion, the block waits with `sdo_oe` and `sclk` low and `busy` high. When a falling edge of `fsync_n` is seen at edge Ef, `sdo_oe` rises at Ef. The first `sclk` rise follows at Ef+1, and the word ends at Ef+32.
- R8: A falling edge of `start_n` while `busy` is high is ignored. It changes neither the word nor its timing, and no conversion follows it.
- R9: While `standby` or `nap` is high, a falling edge of `start_n` is ignored and `busy` stays low.
- R10: While `rst_n` is low at a master edge, the block returns to idle, aborting any conversion or word. `busy`, `sclk` and `sdo_oe` are then low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset, aborts work |
| start_n | input | 1 | Active-low start strobe, falling edge starts a conversion |
| mode_sel | input | 1 | 0: send automatically, 1: wait for frame sync |
| fsync_n | input | 1 | Active-low frame sync, falling edge releases the word in mode 1 |
| standby | input | 1 | Low-power request, blocks starts |
| nap | input | 1 | Deeper low-power request, blocks starts |
| sample_data | input | 14 | Result from the converter stand-in |
| sample_ovr | input | 1 | Over-range flag from the stand-in |
| sclk | output | 1 | Serial clock, half master rate during the word |
| sdo | output | 1 | Serial data, valid when sdo_oe is high |
| sdo_oe | output | 1 | Output enable of the data line; low means high impedance |
| busy | output | 1 | High from the start edge to the end of the word |

## Verification
The main function is driven with random 14-bit samples and random over-range flags in both output modes. The frame-sync wait in the second mode has a random length, which separates a word launched by the sync edge from one launched by the end of conversion. The sample inputs are changed right after the start edge, which shows whether the capture happens at the start edge or later. Directed words of all ones, all zeros and alternating bits catch slot-order and trailing-bit errors. Extra start edges during a conversion, start edges under standby or nap, and resets during the conversion and during the word show that each is ignored or aborts as required.

// File: rtl/adc_seq_pkg.sv
// Shared definitions for the converter sequencer.
// Assumes: one sample word plus an over-range slot and a trailing zero slot.
package adc_seq_pkg;
    localparam int DEF_SAMPLE_W    = 14;
    localparam int DEF_CONV_CYCLES = 24;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CONV = 2'd1,
        ST_WAIT = 2'd2,
        ST_SEND = 2'd3
    } seq_state_t;
endpackage

// File: rtl/adc_fall_detect.sv
// Detects a high-to-low transition of a synchronous input.
// Assumes: din is already in the clk domain; the idle level is high, so the
// history register resets high and a low input during reset gives no edge.
module adc_fall_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic fall
);
    logic prev_q;

    // Keeps the input level of the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= din;
    end

    assign fall = prev_q & ~din;
endmodule

// File: rtl/adc_frame_shifter.sv
// Sends a parallel frame MSB first on a half-rate serial clock.
// Assumes: load is a one-cycle pulse that arrives only while idle. Data
// changes on the master edge that raises sclk; done pulses on the edge of
// the last fall.
module adc_frame_shifter #(
    parameter int FRAME_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [FRAME_W-1:0] frame,
    output logic               sclk,
    output logic               sdo,
    output logic               done
);
    localparam int SLOT_W = $clog2(FRAME_W);

    logic               active_q;
    logic               phase_q;
    logic [SLOT_W-1:0]  slot_q;
    logic [FRAME_W-1:0] shreg_q;
    logic               sclk_q;
    logic               sdo_q;

    assign done = active_q & phase_q & (slot_q == SLOT_W'(FRAME_W - 1));
    assign sclk = sclk_q;
    assign sdo  = sdo_q;

    // Two master cycles per slot: rise with new data, then fall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            phase_q  <= 1'b0;
            slot_q   <= '0;
            shreg_q  <= '0;
            sclk_q   <= 1'b0;
            sdo_q    <= 1'b0;
        end else if (load) begin
            active_q <= 1'b1;
            phase_q  <= 1'b0;
            slot_q   <= '0;
            shreg_q  <= frame;
            sclk_q   <= 1'b0;
            sdo_q    <= 1'b0;
        end else if (active_q) begin
            if (!phase_q) begin
                sclk_q  <= 1'b1;
                sdo_q   <= shreg_q[FRAME_W-1];
                shreg_q <= {shreg_q[FRAME_W-2:0], 1'b0};
                phase_q <= 1'b1;
            end else begin
                sclk_q  <= 1'b0;
                phase_q <= 1'b0;
                slot_q  <= slot_q + 1'b1;
                if (done) begin
                    active_q <= 1'b0;
                    sdo_q    <= 1'b0;
                end
            end
        end
    end

    // R4
    sdo_hold_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q && phase_q && !done && !load) |=> $stable(sdo_q));

    // R5
    sclk_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q && !load) |=> (sclk_q != $past(sclk_q)));

    // R5
    sclk_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active_q |-> !sclk_q);
endmodule

// File: rtl/adc_conv_sequencer.sv
// Conversion sequencer: detects start edges, times the conversion in master
// cycles, captures the sample and hands a framed word to the serial shifter.
// Assumes: all inputs are synchronous to clk; mode_sel is read at the end of
// the conversion; reset is synchronous and active low.
module adc_conv_sequencer
    import adc_seq_pkg::*;
#(
    parameter int SAMPLE_W    = DEF_SAMPLE_W,
    parameter int CONV_CYCLES = DEF_CONV_CYCLES
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_n,
    input  logic                mode_sel,
    input  logic                fsync_n,
    input  logic                standby,
    input  logic                nap,
    input  logic [SAMPLE_W-1:0] sample_data,
    input  logic                sample_ovr,
    output logic                sclk,
    output logic                sdo,
    output logic                sdo_oe,
    output logic                busy
);
    localparam int FRAME_W = SAMPLE_W + 2;
    localparam int CNT_W   = $clog2(CONV_CYCLES);

    seq_state_t          state_q, state_d;
    logic [CNT_W-1:0]    cnt_q;
    logic [SAMPLE_W-1:0] hold_data_q;
    logic                hold_ovr_q;
    logic                start_fall, fs_fall;
    logic                low_pwr, accept, conv_end, fs_go, load, done;
    logic [FRAME_W-1:0]  frame;

    adc_fall_detect u_start_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (start_n),
        .fall (start_fall)
    );

    adc_fall_detect u_fsync_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (fsync_n),
        .fall (fs_fall)
    );

    assign low_pwr  = standby | nap;
    assign accept   = (state_q == ST_IDLE) && start_fall && !low_pwr;
    assign conv_end = (state_q == ST_CONV) && (cnt_q == CNT_W'(CONV_CYCLES - 1));
    assign fs_go    = (state_q == ST_WAIT) && fs_fall;
    assign load     = (conv_end && !mode_sel) || fs_go;
    assign frame    = {hold_ovr_q, hold_data_q, 1'b0};

    // Next-state choice of the sequence.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept)   state_d = ST_CONV;
            ST_CONV: if (conv_end) state_d = mode_sel ? ST_WAIT : ST_SEND;
            ST_WAIT: if (fs_go)    state_d = ST_SEND;
            ST_SEND: if (done)     state_d = ST_IDLE;
            default:               state_d = ST_IDLE;
        endcase
    end

    // State register and conversion cycle counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= (state_q == ST_CONV && !conv_end) ? cnt_q + 1'b1 : '0;
        end
    end

    // Captures the sample at the accepted start edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_data_q <= '0;
            hold_ovr_q  <= 1'b0;
        end else if (accept) begin
            hold_data_q <= sample_data;
            hold_ovr_q  <= sample_ovr;
        end
    end

    adc_frame_shifter #(.FRAME_W(FRAME_W)) u_shifter (
        .clk  (clk),
        .rst_n(rst_n),
        .load (load),
        .frame(frame),
        .sclk (sclk),
        .sdo  (sdo),
        .done (done)
    );

    assign sdo_oe = (state_q == ST_SEND);
    assign busy   = (state_q != ST_IDLE);

    // R2
    conv_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_end |=> (state_q != ST_CONV));

    // R2
    conv_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CONV && !conv_end) |=> (state_q == ST_CONV && cnt_q == $past(cnt_q) + 1'b1));

    // R8
    busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start_fall) |=> $stable(hold_data_q) && $stable(hold_ovr_q));

    // R9
    low_power_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && low_pwr) |=> (state_q == ST_IDLE));

    // R7
    wait_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && !fs_fall) |=> (!sdo_oe && !sclk && busy));
endmodule

// File: tb/tb_adc_conv_sequencer.sv
module tb_adc_conv_sequencer;
    localparam int CLK_PERIOD = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_n = 1'b1;
    logic        mode_sel = 1'b0;
    logic        fsync_n = 1'b1;
    logic        standby = 1'b0;
    logic        nap = 1'b0;
    logic [13:0] sample_data = '0;
    logic        sample_ovr = 1'b0;
    logic        sclk, sdo, sdo_oe, busy;

    int checks = 0;
    int errors = 0;

    adc_conv_sequencer dut (
        .clk(clk), .rst_n(rst_n), .start_n(start_n), .mode_sel(mode_sel),
        .fsync_n(fsync_n), .standby(standby), .nap(nap),
        .sample_data(sample_data), .sample_ovr(sample_ovr),
        .sclk(sclk), .sdo(sdo), .sdo_oe(sdo_oe), .busy(busy)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [15:0] exp_frame(logic [13:0] d, logic ovr);
        return {ovr, d, 1'b0};
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One start, optional extra start during conversion, word received and checked.
    task automatic run_word(logic mode, logic [13:0] d, logic ovr, logic extra);
        logic [15:0] rx;
        int wait_n;
        rx = '0;
        sample_data = d; sample_ovr = ovr; mode_sel = mode;
        @(negedge clk) start_n = 1'b0;
        @(negedge clk) start_n = 1'b1;              // k = 1
        check("R1 busy after start", busy, 1);
        sample_data = ~d; sample_ovr = ~ovr;
        for (int k = 2; k <= 25; k++) begin
            @(negedge clk);
            if (extra && k == 10) start_n = 1'b0;
            if (extra && k == 11) start_n = 1'b1;
            if (k == 24) check("R2 sclk low in conversion", sclk, 0);
        end
        check("R2 sclk low after E24", sclk, 0);
        if (!mode) begin
            check("R6 oe at E24", sdo_oe, 1);
        end else begin
            check("R7 oe low at E24", sdo_oe, 0);
            wait_n = 1 + int'($urandom % 8);
            for (int w = 0; w < wait_n; w++) begin
                @(negedge clk);
                check("R7 waiting released", {busy, sdo_oe, sclk}, 3'b100);
            end
            fsync_n = 1'b0;
            @(negedge clk) fsync_n = 1'b1;
            check("R7 oe after sync edge", {sdo_oe, sclk}, 2'b10);
        end
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            check("R5 sclk high", sclk, 1);
            rx[15-i] = sdo;
            @(negedge clk);
            check("R4 sdo held on fall", sdo, rx[15-i]);
            if (i == 15) check("R6 end of word busy/oe", {busy, sdo_oe}, 2'b00);
            else         check("R5 sclk low", {sclk, sdo_oe}, 2'b01);
        end
        check("R3 frame order", rx, exp_frame(d, ovr));
        repeat (3) @(negedge clk);
        check("R8 no stray conversion", {busy, sclk}, 2'b00);
        sample_data = d; sample_ovr = ovr;
    endtask

    task automatic low_power_try(logic sb, logic np);
        standby = sb; nap = np;
        @(negedge clk) start_n = 1'b0;
        @(negedge clk) start_n = 1'b1;
        check("R9 start ignored in low power", busy, 0);
        repeat (30) @(negedge clk);
        check("R9 still idle", {busy, sclk, sdo_oe}, 3'b000);
        standby = 1'b0; nap = 1'b0;
        @(negedge clk);
    endtask

    task automatic abort_at(int k_abort);
        mode_sel = 1'b0;
        @(negedge clk) start_n = 1'b0;
        @(negedge clk) start_n = 1'b1;
        for (int k = 2; k <= k_abort; k++) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R10 abort clears", {busy, sclk, sdo_oe}, 3'b000);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (40) @(negedge clk);
        check("R10 stays idle after abort", {busy, sclk, sdo_oe}, 3'b000);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5A17));
        repeat (3) @(negedge clk);
        check("R10 reset state", {busy, sclk, sdo_oe}, 3'b000);
        rst_n = 1'b1;
        @(negedge clk);
        run_word(1'b0, 14'h3FFF, 1'b1, 1'b0);
        run_word(1'b0, 14'h0000, 1'b0, 1'b0);
        run_word(1'b1, 14'h2AAA, 1'b0, 1'b0);
        run_word(1'b0, 14'h1555, 1'b1, 1'b1);   // R8 extra start
        run_word(1'b1, 14'h0001, 1'b1, 1'b1);
        low_power_try(1'b1, 1'b0);
        low_power_try(1'b0, 1'b1);
        abort_at(10);
        abort_at(40);
        for (int n = 0; n < 14; n++)
            run_word(1'($urandom), 14'($urandom), 1'($urandom), 1'($urandom));
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule